// File: doc/BRIEF.md
# Fault Event Counter Bank

This block keeps statistics on validated fault events coming from several
independent fault channels. Every channel delivers a one-cycle enter pulse when
its fault condition becomes valid and a one-cycle exit pulse when the condition
goes away. For every channel the block keeps five counters side by side:
- a count over the whole life of the device;
- a count over a sliding recent window that decays by itself;
- a count of repeated faults with no recovery in between;
- a count for events that arrive while the system is asleep;
- a count for events that arrive while the system is awake.

A per-channel alarm latches once the recent-window count reaches a threshold
the host has programmed. A service clear drops the alarms and the short-term
state (window and repeat counters) and leaves the long-term counts as they
were. Each clear is logged through a clear counter and the reason code of the
most recent clear. A host bus wrapper reads every value through a
combinational register read port.

The sliding window is split into a ring of sub-window buckets. An external
tick closes the current sub-window. When a bucket is reused, its contents
leave the running sum. Every counter stops at its largest value and raises a
sticky saturation flag when it is full and an event arrives.

Top module: `fault_evt_counters`

## Requirements
- R1: The lifetime count of a channel goes up by one at every clock edge where its enter input is high. The sleep state does not matter, and the counts of the other channels do not change.
- R2: An enter event goes up the sleep count when `asleep` is 1 at that edge, and goes up the awake count when `asleep` is 0.
- R3: The window count is the sum of NB sub-window buckets. Events go into the current bucket. At each `sub_tick`, the oldest bucket is subtracted from the sum and reused as the new current bucket, so an event stops being counted at the NB-th tick after it. With no tick, no enter and no clear, the window count does not change.
- R4: The repeat count goes up at every enter event. After an exit pulse, if `recov_len` edges follow with no enter, the count returns to 0 at the last of them. An enter inside that interval cancels the recovery.
- R5: No counter wraps. A counter at its maximum stays there, and an enter that finds it full sets that counter's sticky flag. The flags word has these bits: bit 0 lifetime, bit 1 window, bit 2 repeat, bit 3 sleep, bit 4 awake.
- R6: The alarm of a channel is set one edge after the window count is at least a nonzero `alarm_thresh`. It stays set while the window decays, and only a service clear drops it.
- R7: A service clear sets to zero, for every channel, the alarm, the window count with its buckets, the repeat count, and the window and repeat flags. Lifetime, sleep and awake counts and their flags are kept.
- R8: Each service clear increases the clear count by one, saturating. It also stores `clear_reason` as the last reason. Both are 0 after reset.
- R9: `rd_data` is selected by `rd_addr`. The upper bits give the channel; the low three bits give the field: 0 lifetime, 1 window, 2 repeat, 3 sleep, 4 awake, 5 flags, 6 last reason, 7 clear count. A channel index of NF or more reads 0.
- R10: An enter in the same cycle as a service clear is still counted in the lifetime and sleep/awake counts. It is not counted in the window or repeat counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_enter | input | NF | One-cycle validated fault-entry pulse per channel |
| fault_exit | input | NF | One-cycle fault-exit pulse per channel |
| asleep | input | 1 | Power state at the event: 1 asleep, 0 awake |
| sub_tick | input | 1 | Closes the current sub-window |
| recov_len | input | RW | Clear interval (edges) needed for recovery |
| alarm_thresh | input | CNT_W | Window count that sets the alarm; 0 disables |
| svc_clear | input | 1 | Service clear command |
| clear_reason | input | RSW | Reason code stored with a clear |
| rd_addr | input | ADDR_W | Read address: {channel, field} |
| rd_data | output | CNT_W | Read data of the selected field |
| alarm | output | NF | Latched alarm per channel |

## Verification
The assertions assume that these inputs are synchronous single-cycle pulses:
- enter and exit pulses;
- sub-window ticks;
- clears.

They also assume that `recov_len` and `alarm_thresh` stay constant while a recovery interval or an alarm decision is pending.

The stimulus follows those assumptions:
- it changes every input on the falling edge;
- it sets the threshold and recovery length once, before any event;
- it produces the only multi-cycle enter level, in the saturation test, as a string of back-to-back one-edge events.

// File: rtl/fec_pkg.sv
// Package: shared field selectors and flag bit positions for the fault
// event counter bank. Assumes the host decodes field codes 0..7.
package fec_pkg;
    typedef enum logic [2:0] {
        SEL_TOTAL  = 3'd0,
        SEL_WINDOW = 3'd1,
        SEL_CONSEC = 3'd2,
        SEL_SLEEP  = 3'd3,
        SEL_AWAKE  = 3'd4,
        SEL_FLAGS  = 3'd5,
        SEL_REASON = 3'd6,
        SEL_CLRCNT = 3'd7
    } fld_sel_e;

    localparam int FLG_TOTAL  = 0;
    localparam int FLG_WINDOW = 1;
    localparam int FLG_CONSEC = 2;
    localparam int FLG_SLEEP  = 3;
    localparam int FLG_AWAKE  = 4;
    localparam int FLG_W      = 5;
endpackage

// File: rtl/sat_counter.sv
// Saturating event counter with a sticky overflow flag.
// Assumes: inc is a per-edge event strobe; clr has priority over inc.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         sat
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count events, hold at maximum and flag lost events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sat <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            sat <= 1'b0;
        end else if (inc) begin
            if (cnt == MAXV) sat <= 1'b1;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R5
    hold_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV));
    // R1
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt >= $past(cnt)));
    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> sat);
endmodule

// File: rtl/window_counter.sv
// Sliding-window event counter built from a ring of NB sub-window buckets.
// On each tick the pointer advances; the bucket it lands on (the oldest)
// is subtracted from the running sum and reused. Assumes SW >= BW+log2(NB).
module window_counter #(
    parameter int NB = 4,
    parameter int BW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          tick,
    input  logic          clr,
    output logic [SW-1:0] sum,
    output logic          sat
);
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [BW-1:0] BMAX = {BW{1'b1}};
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    logic [BW-1:0] bkt [NB];
    logic [PW-1:0] cur;
    logic [PW-1:0] nxt;
    logic          full;
    logic          add;
    logic [SW-1:0] sum_n;

    // Next pointer, bucket-full test and next running sum.
    always_comb begin
        nxt   = (cur == LAST) ? '0 : cur + 1'b1;
        full  = tick ? 1'b0 : (bkt[cur] == BMAX);
        add   = inc & ~full;
        sum_n = sum - (tick ? {{(SW-BW){1'b0}}, bkt[nxt]} : '0)
                    + {{(SW-1){1'b0}}, add};
    end

    // Advance the ring, accumulate events and keep the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NB; i++) bkt[i] <= '0;
            cur <= '0;
            sum <= '0;
            sat <= 1'b0;
        end else begin
            if (tick) begin
                cur      <= nxt;
                bkt[nxt] <= {{(BW-1){1'b0}}, add};
            end else if (add) begin
                bkt[cur] <= bkt[cur] + 1'b1;
            end
            if (inc && !add) sat <= 1'b1;
            sum <= sum_n;
        end
    end

    // R7
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0));
    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !inc && !clr) |=> $stable(sum));
    // R3
    no_growth_on_idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !inc && !clr) |=> (sum <= $past(sum)));
endmodule

// File: rtl/consec_tracker.sv
// Repeat-fault counter: counts enter events and returns to zero once an
// exit pulse is followed by recov_len edges with no enter.
// Assumes recov_len is stable during a recovery interval; 0 acts as 1.
module consec_tracker #(
    parameter int W  = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter,
    input  logic          exit_p,
    input  logic          clr,
    input  logic [RW-1:0] recov_len,
    output logic [W-1:0]  cnt,
    output logic          sat
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic          armed;
    logic [RW-1:0] timer;
    logic          recovered;

    // Recovery completes when the quiet interval has reached its length.
    always_comb begin
        recovered = armed && !enter && !exit_p &&
                    (({1'b0, timer} + 1'b1) >= {1'b0, recov_len});
    end

    // Track repeats, arm on exit, reset the count once recovery is observed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt   <= '0;
            sat   <= 1'b0;
            armed <= 1'b0;
            timer <= '0;
        end else if (enter) begin
            if (cnt == MAXV) sat <= 1'b1;
            else             cnt <= cnt + 1'b1;
            armed <= exit_p;
            timer <= '0;
        end else if (exit_p) begin
            armed <= 1'b1;
            timer <= '0;
        end else if (recovered) begin
            cnt   <= '0;
            armed <= 1'b0;
            timer <= '0;
        end else if (armed) begin
            timer <= timer + 1'b1;
        end
    end

    // R4
    repeat_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !clr && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !enter && !clr) |=> $stable(cnt));
    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/audit_log.sv
// Audit trail of service clears: a saturating clear count and the reason
// code of the most recent clear. Assumes svc_clear is a one-edge strobe.
module audit_log #(
    parameter int W   = 16,
    parameter int RSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_clear,
    input  logic [RSW-1:0] reason,
    output logic [W-1:0]   clr_cnt,
    output logic [RSW-1:0] last_reason
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Record every clear and its reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt     <= '0;
            last_reason <= '0;
        end else if (svc_clear) begin
            if (clr_cnt != MAXV) clr_cnt <= clr_cnt + 1'b1;
            last_reason <= reason;
        end
    end

    // R8
    clear_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_clear && clr_cnt != MAXV) |=> (clr_cnt == $past(clr_cnt) + 1'b1));
    // R8
    reason_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_clear |=> ($stable(last_reason) && $stable(clr_cnt)));
endmodule

// File: rtl/fault_evt_counters.sv
// Top of the fault event counter bank. One lane per fault channel holds
// lifetime, sleep, awake, window and repeat counters plus a latched alarm.
// A shared audit log records service clears. Reads are combinational.
// Assumes CNT_W > RSW and CNT_W > 5, CNT_W >= BW + log2(NB).
module fault_evt_counters #(
    parameter int NF    = 4,
    parameter int CNT_W = 16,
    parameter int NB    = 4,
    parameter int BW    = 8,
    parameter int RW    = 8,
    parameter int RSW   = 4,
    localparam int FIDX_W = (NF > 1) ? $clog2(NF) : 1,
    localparam int ADDR_W = FIDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NF-1:0]     fault_enter,
    input  logic [NF-1:0]     fault_exit,
    input  logic              asleep,
    input  logic              sub_tick,
    input  logic [RW-1:0]     recov_len,
    input  logic [CNT_W-1:0]  alarm_thresh,
    input  logic              svc_clear,
    input  logic [RSW-1:0]    clear_reason,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NF-1:0]     alarm
);
    import fec_pkg::*;

    logic [CNT_W-1:0] tot_c [NF];
    logic [CNT_W-1:0] win_c [NF];
    logic [CNT_W-1:0] rep_c [NF];
    logic [CNT_W-1:0] slp_c [NF];
    logic [CNT_W-1:0] awk_c [NF];
    logic [FLG_W-1:0] flg   [NF];
    logic [CNT_W-1:0] clr_cnt;
    logic [RSW-1:0]   last_reason;

    for (genvar f = 0; f < NF; f++) begin : g_lane
        logic tot_s, win_s, rep_s, slp_s, awk_s;

        sat_counter #(.W(CNT_W)) u_total (
            .clk(clk), .rst_n(rst_n), .inc(fault_enter[f]), .clr(1'b0),
            .cnt(tot_c[f]), .sat(tot_s));

        sat_counter #(.W(CNT_W)) u_sleep (
            .clk(clk), .rst_n(rst_n), .inc(fault_enter[f] & asleep), .clr(1'b0),
            .cnt(slp_c[f]), .sat(slp_s));

        sat_counter #(.W(CNT_W)) u_awake (
            .clk(clk), .rst_n(rst_n), .inc(fault_enter[f] & ~asleep), .clr(1'b0),
            .cnt(awk_c[f]), .sat(awk_s));

        window_counter #(.NB(NB), .BW(BW), .SW(CNT_W)) u_window (
            .clk(clk), .rst_n(rst_n), .inc(fault_enter[f]), .tick(sub_tick),
            .clr(svc_clear), .sum(win_c[f]), .sat(win_s));

        consec_tracker #(.W(CNT_W), .RW(RW)) u_repeat (
            .clk(clk), .rst_n(rst_n), .enter(fault_enter[f]),
            .exit_p(fault_exit[f]), .clr(svc_clear), .recov_len(recov_len),
            .cnt(rep_c[f]), .sat(rep_s));

        // Gather the per-counter saturation flags into one word.
        always_comb begin
            flg[f] = '0;
            flg[f][FLG_TOTAL]  = tot_s;
            flg[f][FLG_WINDOW] = win_s;
            flg[f][FLG_CONSEC] = rep_s;
            flg[f][FLG_SLEEP]  = slp_s;
            flg[f][FLG_AWAKE]  = awk_s;
        end

        // Latch the alarm when the window reaches the threshold.
        always_ff @(posedge clk) begin
            if (!rst_n || svc_clear)
                alarm[f] <= 1'b0;
            else if (alarm_thresh != '0 && win_c[f] >= alarm_thresh)
                alarm[f] <= 1'b1;
        end

        // R6
        alarm_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm[f] && !svc_clear) |=> alarm[f]);
        // R7
        alarm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
            svc_clear |=> !alarm[f]);
    end

    audit_log #(.W(CNT_W), .RSW(RSW)) u_audit (
        .clk(clk), .rst_n(rst_n), .svc_clear(svc_clear), .reason(clear_reason),
        .clr_cnt(clr_cnt), .last_reason(last_reason));

    logic [FIDX_W-1:0] rd_f;
    fld_sel_e          rd_sel;

    // Decode the read address and select the requested field.
    always_comb begin
        rd_f    = rd_addr[ADDR_W-1:3];
        rd_sel  = fld_sel_e'(rd_addr[2:0]);
        rd_data = '0;
        if (int'(rd_f) < NF) begin
            unique case (rd_sel)
                SEL_TOTAL:  rd_data = tot_c[rd_f];
                SEL_WINDOW: rd_data = win_c[rd_f];
                SEL_CONSEC: rd_data = rep_c[rd_f];
                SEL_SLEEP:  rd_data = slp_c[rd_f];
                SEL_AWAKE:  rd_data = awk_c[rd_f];
                SEL_FLAGS:  rd_data = {{(CNT_W-FLG_W){1'b0}}, flg[rd_f]};
                SEL_REASON: rd_data = {{(CNT_W-RSW){1'b0}}, last_reason};
                SEL_CLRCNT: rd_data = clr_cnt;
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: tb/test_fault_evt_counters.sv
module test_fault_evt_counters;
    localparam int CLK_P  = 10;
    localparam int NF     = 4;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NF-1:0]     fault_enter = '0;
    logic [NF-1:0]     fault_exit = '0;
    logic              asleep = 1'b0;
    logic              sub_tick = 1'b0;
    logic [3:0]        recov_len = 4'd3;
    logic [CNT_W-1:0]  alarm_thresh = 8'd5;
    logic              svc_clear = 1'b0;
    logic [3:0]        clear_reason = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [CNT_W-1:0]  rd_data;
    logic [NF-1:0]     alarm;

    always #(CLK_P/2) clk = ~clk;

    fault_evt_counters #(.NF(NF), .CNT_W(CNT_W), .NB(4), .BW(4), .RW(4), .RSW(4))
        i_fault_evt_counters (
        .clk(clk), .rst_n(rst_n), .fault_enter(fault_enter), .fault_exit(fault_exit),
        .asleep(asleep), .sub_tick(sub_tick), .recov_len(recov_len),
        .alarm_thresh(alarm_thresh), .svc_clear(svc_clear),
        .clear_reason(clear_reason), .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm(alarm));

    typedef struct {
        bit    is_alarm;
        int    fidx;
        int    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic int adr(int f, int s);
        return f * 8 + s;
    endfunction

    // Driver side: put the read address and push the expected value.
    task automatic exp_rd(int f, int s, int exp, string tag);
        @(negedge clk);
        rd_addr = ADDR_W'(adr(f, s));
        sb_q.push_back('{1'b0, f, exp, tag});
        @(negedge clk);
    endtask

    task automatic exp_alarm(int f, int exp, string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, f, exp, tag});
        @(negedge clk);
    endtask

    // Monitor: pop one expected item per cycle, compare away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                int act;
                it  = sb_q.pop_front();
                act = it.is_alarm ? int'(alarm[it.fidx]) : int'(rd_data);
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%0d expected=%0d", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic pulse_enter(int f, bit slp);
        @(negedge clk);
        fault_enter[f] = 1'b1;
        asleep = slp;
        @(negedge clk);
        fault_enter[f] = 1'b0;
        asleep = 1'b0;
    endtask

    task automatic pulse_exit(int f);
        @(negedge clk);
        fault_exit[f] = 1'b1;
        @(negedge clk);
        fault_exit[f] = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        sub_tick = 1'b1;
        @(negedge clk);
        sub_tick = 1'b0;
    endtask

    task automatic do_clear(int reason);
        @(negedge clk);
        svc_clear = 1'b1;
        clear_reason = 4'(reason);
        @(negedge clk);
        svc_clear = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // Reset state
        exp_rd(0, 0, 0, "R1 lifetime after reset");
        exp_alarm(0, 0, "R6 alarm after reset");
        exp_rd(0, 7, 0, "R8 clear count after reset");

        // Mixed power states on channel 0
        for (int i = 0; i < 3; i++) pulse_enter(0, 1'b0);
        for (int i = 0; i < 2; i++) pulse_enter(0, 1'b1);
        exp_rd(0, 0, 5, "R1 lifetime count");
        exp_rd(1, 0, 0, "R1 other channel untouched");
        exp_rd(0, 4, 3, "R2 awake count");
        exp_rd(0, 3, 2, "R2 sleep count");
        exp_rd(0, 1, 5, "R3 window count");
        exp_rd(0, 2, 5, "R4 repeat count");
        exp_alarm(0, 1, "R6 alarm at threshold");

        // Window decay: events leave at the NB-th tick
        for (int i = 0; i < 3; i++) do_tick();
        exp_rd(0, 1, 5, "R3 window before last tick");
        do_tick();
        exp_rd(0, 1, 0, "R3 window after NB ticks");
        exp_alarm(0, 1, "R6 alarm held after decay");

        // Recovery cancelled, then completed
        pulse_exit(0);
        pulse_enter(0, 1'b0);
        exp_rd(0, 2, 6, "R4 enter cancels recovery");
        pulse_exit(0);
        idle(5);
        exp_rd(0, 2, 0, "R4 recovery resets repeat count");

        // Service clear keeps history
        pulse_enter(0, 1'b0);
        pulse_enter(0, 1'b0);
        exp_rd(0, 1, 3, "R3 window refill");
        do_clear(9);
        exp_alarm(0, 0, "R7 alarm cleared");
        exp_rd(0, 1, 0, "R7 window cleared");
        exp_rd(0, 2, 0, "R7 repeat cleared");
        exp_rd(0, 0, 8, "R7 lifetime kept");
        exp_rd(0, 4, 6, "R7 awake kept");
        exp_rd(0, 3, 2, "R7 sleep kept");
        exp_rd(0, 7, 1, "R8 clear count");
        exp_rd(2, 6, 9, "R8 last reason");

        // Enter in the clear cycle
        @(negedge clk);
        fault_enter[2] = 1'b1;
        asleep = 1'b1;
        svc_clear = 1'b1;
        clear_reason = 4'd3;
        @(negedge clk);
        fault_enter[2] = 1'b0;
        asleep = 1'b0;
        svc_clear = 1'b0;
        exp_rd(2, 0, 1, "R10 lifetime counts clear-cycle event");
        exp_rd(2, 3, 1, "R10 sleep counts clear-cycle event");
        exp_rd(2, 1, 0, "R10 window ignores clear-cycle event");
        exp_rd(2, 2, 0, "R10 repeat ignores clear-cycle event");
        exp_rd(1, 7, 2, "R8 second clear counted");
        exp_rd(1, 6, 3, "R8 second reason");

        // Saturation on channel 3
        @(negedge clk);
        fault_enter[3] = 1'b1;
        idle(260);
        fault_enter[3] = 1'b0;
        exp_rd(3, 0, 255, "R5 lifetime saturates");
        exp_rd(3, 4, 255, "R5 awake saturates");
        exp_rd(3, 2, 255, "R5 repeat saturates");
        exp_rd(3, 1, 15, "R5 window bucket saturates");
        exp_rd(3, 5, 23, "R5 flags all but sleep");
        exp_alarm(3, 1, "R6 alarm channel 3");
        do_clear(5);
        exp_rd(3, 5, 17, "R7 short-term flags cleared");
        exp_rd(3, 0, 255, "R7 saturated lifetime kept");
        exp_rd(3, 1, 0, "R9 window field after clear");
        exp_alarm(3, 0, "R7 alarm channel 3 cleared");
        exp_rd(0, 7, 3, "R9 clear count via channel 0");

        idle(3);
        done = 1;
        finish_run();
    end
endmodule